// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

The block holds a set of down-counting timers that share one bus clock and one word-addressed register port. Each timer has four registers of its own: a live count, a reload value and two match values. All timers keep their control settings in one packed control word. Each timer owns a four-bit field of that word. Those bits turn the timer on, choose its tick source, gate its overflow into the shared interrupt line and switch on a pulse-width output built from the two match values.

The tick source is either every bus clock or an external one-cycle enable, `tick_1m`. The system drives `tick_1m` at one million pulses per second. An enabled timer counts down by one on each selected tick. On the tick that finds it at zero, it reloads and raises an overflow flag. A second word clears control bits without a read-modify-write: a one written there clears the matching control bit. A third word collects the overflow flags, and software writes a one there to clear a flag.

Each timer runs a small state machine with the states `CH_OFF` and `CH_RUN`. `CH_OFF` goes to `CH_RUN` when the enable bit is seen set. `CH_RUN` goes back to `CH_OFF` when the enable bit is seen clear. Each timer with pulse support also has an output machine with the states `PW_LOW` and `PW_HIGH`. `PW_LOW` goes to `PW_HIGH` on a match-1 hit. `PW_HIGH` goes to `PW_LOW` on a match-2 hit or when pulse mode is off.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `pwm_out` is all zero.
- R2: Timer n (1 to 8) has its register set at word base 4*(n-1) for n up to 3 and at base 4*(n-1)+4 for n from 4 upward. Within a set, +0 is the count, +1 the reload value, +2 match 1 and +3 match 2. Word 12 is the control word, word 13 the clear alias, word 14 the overflow flags (bit n-1 for timer n), and word 15 is reserved. A read returns its data on `rdata` one clock after `rd_en`, and reload and match values read back as written.
- R3: Timer n uses bits 4*(n-1)+3 down to 4*(n-1) of the control word. In that field, bit 0 is enable, bit 1 selects the tick source (1 = `tick_1m`, 0 = every clock), bit 2 is the overflow interrupt enable and bit 3 is pulse mode.
- R4: A write to a timer's count word loads the counter directly, and a disabled timer holds its count.
- R5: An enabled timer with tick source 1 counts down by one on each clock edge where `tick_1m` is high. Counting starts from the second edge after the enabling write, and the count is unchanged on edges without a tick.
- R6: With tick source 0 the timer counts down on every edge. If k idle cycles separate the enabling write from the write that disables it, the count drops by exactly k.
- R7: A tick that finds the count at zero loads the reload value and sets the timer's overflow flag.
- R8: Writing word 14 clears each flag whose data bit is 1, and a 0 data bit leaves its flag unchanged.
- R9: `irq` is high exactly when some timer has both its flag and its interrupt enable set.
- R10: Writing word 13 clears each control bit whose data bit is 1, leaves the other bits unchanged, and word 13 reads zero.
- R11: In pulse mode, `pwm_out[n-1]` rises one clock after the count equals match 1 and falls one clock after it equals match 2, with match 1 taking precedence. One clock after pulse mode is off, the output is 0.
- R12: Timers without pulse support (by default timers 5 to 8) read their bit 3 as zero and keep their output at 0.
- R13: Reserved and unmapped words (15, and 36 upward) read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1m | input | 1 | Slow tick enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| irq | output | 1 | Combined overflow interrupt |
| pwm_out | output | 8 | Per-timer pulse output |

## Verification
The assertions assume that the bus carries at most one write per cycle, that `addr` and `wdata` are steady during the strobe, and that `tick_1m` is synchronous to `clk`. The stimulus changes every input on the falling edge and issues each access as a single one-cycle strobe. It drives `tick_1m` only as isolated one-cycle pulses, with at least one idle cycle after a control write. That keeps the `CH_OFF` to `CH_RUN` step out of the counted window.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    typedef enum logic { CH_OFF, CH_RUN } ch_state_t;
    typedef enum logic { PW_LOW, PW_HIGH } pw_state_t;

    localparam int LOW_GROUP = 3;
    localparam int CTRL_WORD = 4 * LOW_GROUP;
    localparam int CLR_WORD  = CTRL_WORD + 1;
    localparam int FLAG_WORD = CTRL_WORD + 2;

    localparam int FB_EN   = 0;
    localparam int FB_SLOW = 1;
    localparam int FB_IRQ  = 2;
    localparam int FB_PWM  = 3;

    function automatic int set_base(input int ch);
        return (ch < LOW_GROUP) ? 4 * ch : 4 * ch + 4;
    endfunction

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             step,
    output logic             wrap
);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (en)  state_d = CH_RUN;
            CH_RUN: if (!en) state_d = CH_OFF;
        endcase
    end

    always_comb begin
        step = (state_q == CH_RUN) && en && tick && !ld;
        wrap = step && (count_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (ld)   count_q <= ld_val;
        else if (wrap) count_q <= reload;
        else if (step) count_q <= count_q - 1'b1;
    end

    assign count = count_q;

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
    import tmr_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] match1,
    input  logic [CNT_W-1:0] match2,
    output logic             pwm
);

    pw_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PW_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_LOW:  if (en && count == match1) state_d = PW_HIGH;
            PW_HIGH: if (!en || (count != match1 && count == match2)) state_d = PW_LOW;
        endcase
    end

    always_comb begin
        pwm = (state_q == PW_HIGH);
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int                   NUM_CH   = 8,
    parameter int                   CNT_W    = 32,
    parameter int                   ADDR_W   = 6,
    parameter int                   DATA_W   = 32,
    parameter logic [NUM_CH-1:0]    PWM_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1m,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int CTL_W = 4 * NUM_CH;
    localparam int AW2   = ADDR_W - 2;

    function automatic logic [CTL_W-1:0] ctl_mask_f();
        logic [CTL_W-1:0] m;
        for (int i = 0; i < NUM_CH; i++)
            m[4*i +: 4] = PWM_MASK[i] ? 4'hF : 4'h7;
        return m;
    endfunction

    localparam logic [CTL_W-1:0] CTL_MASK = ctl_mask_f();

    logic [CTL_W-1:0]             ctrl_q;
    logic [NUM_CH-1:0]            flag_q;
    logic [NUM_CH-1:0]            wrap;
    logic [NUM_CH-1:0]            step;
    logic [NUM_CH-1:0]            ld;
    logic [NUM_CH-1:0]            ie_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] count_v;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_v;
    logic [NUM_CH-1:0][CNT_W-1:0] m1_v;
    logic [NUM_CH-1:0][CNT_W-1:0] m2_v;
    logic [DATA_W-1:0]            rd_mux;

    logic wr_ctl, wr_clr, wr_flag;
    assign wr_ctl  = wr_en && (addr == ADDR_W'(CTRL_WORD));
    assign wr_clr  = wr_en && (addr == ADDR_W'(CLR_WORD));
    assign wr_flag = wr_en && (addr == ADDR_W'(FLAG_WORD));

    // shared packed control word with clear alias
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_ctl) ctrl_q <= wdata[CTL_W-1:0] & CTL_MASK;
        else if (wr_clr) ctrl_q <= ctrl_q & ~wdata[CTL_W-1:0];
    end

    // overflow flags: set by wrap, cleared by writing ones
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~(wr_flag ? wdata[NUM_CH-1:0] : {NUM_CH{1'b0}})) | wrap;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = set_base(i);

        logic             hit;
        logic [CNT_W-1:0] rl_q, ma_q, mb_q;
        logic             ch_en, ch_slow, ch_pwm;

        assign hit     = (addr[ADDR_W-1:2] == AW2'(BASE / 4));
        assign ch_en   = ctrl_q[4*i + FB_EN];
        assign ch_slow = ctrl_q[4*i + FB_SLOW];
        assign ch_pwm  = ctrl_q[4*i + FB_PWM];
        assign ie_vec[i] = ctrl_q[4*i + FB_IRQ];
        assign ld[i]   = wr_en && hit && (addr[1:0] == 2'd0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rl_q <= '0;
                ma_q <= '0;
                mb_q <= '0;
            end else if (wr_en && hit) begin
                if (addr[1:0] == 2'd1) rl_q <= wdata[CNT_W-1:0];
                if (addr[1:0] == 2'd2) ma_q <= wdata[CNT_W-1:0];
                if (addr[1:0] == 2'd3) mb_q <= wdata[CNT_W-1:0];
            end
        end

        assign reload_v[i] = rl_q;
        assign m1_v[i]     = ma_q;
        assign m2_v[i]     = mb_q;

        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (ch_en),
            .tick   (ch_slow ? tick_1m : 1'b1),
            .ld     (ld[i]),
            .ld_val (wdata[CNT_W-1:0]),
            .reload (rl_q),
            .count  (count_v[i]),
            .step   (step[i]),
            .wrap   (wrap[i])
        );

        if (PWM_MASK[i]) begin : g_pwm
            tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (ch_pwm),
                .count  (count_v[i]),
                .match1 (ma_q),
                .match2 (mb_q),
                .pwm    (pwm_out[i])
            );
        end else begin : g_nopwm
            assign pwm_out[i] = 1'b0;
        end
    end

    assign irq = |(flag_q & ie_vec);

    // read path
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(CTRL_WORD)) rd_mux = DATA_W'(ctrl_q);
        if (addr == ADDR_W'(FLAG_WORD)) rd_mux = DATA_W'(flag_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr[ADDR_W-1:2] == AW2'(set_base(i) / 4)) begin
                unique case (addr[1:0])
                    2'd0: rd_mux = DATA_W'(count_v[i]);
                    2'd1: rd_mux = DATA_W'(reload_v[i]);
                    2'd2: rd_mux = DATA_W'(m1_v[i]);
                    2'd3: rd_mux = DATA_W'(m2_v[i]);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_bank_pkg::*;
#(
    parameter int                NUM_CH   = 8,
    parameter int                CNT_W    = 32,
    parameter int                ADDR_W   = 6,
    parameter int                DATA_W   = 32,
    parameter logic [NUM_CH-1:0] PWM_MASK = 8'h0F
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wdata,
    input logic [4*NUM_CH-1:0]             ctrl_q,
    input logic [NUM_CH-1:0]               flag_q,
    input logic [NUM_CH-1:0]               wrap,
    input logic [NUM_CH-1:0]               step,
    input logic [NUM_CH-1:0]               ld,
    input logic [NUM_CH-1:0][CNT_W-1:0]    count_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]    reload_v,
    input logic                            irq,
    input logic [NUM_CH-1:0]               pwm_out
);

    localparam int CTL_W = 4 * NUM_CH;

    // R10: bits written as one to the clear alias are zero afterwards
    a_r10_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CLR_WORD)) |=> ((ctrl_q & $past(wdata[CTL_W-1:0])) == '0));

    // R9: the interrupt line needs a pending flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7: a wrap sets the flag and loads the reload value
        a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> flag_q[i]);
        a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> (count_v[i] == $past(reload_v[i])));
        // R4: no step and no load keeps the count
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!step[i] && !ld[i]) |=> $stable(count_v[i]));
        // R5: a step from a nonzero count decrements by one
        a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
            (step[i] && count_v[i] != '0) |=> (count_v[i] == $past(count_v[i]) - 1'b1));
        // R11: pulse mode off forces the output low one clock later
        a_r11_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[4*i + FB_PWM] |=> !pwm_out[i]);
        if (!PWM_MASK[i]) begin : g_nopwm
            // R12: unsupported pulse channel
            a_r12_no_pwm: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_q[4*i + FB_PWM] && !pwm_out[i]);
        end
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_CH   (NUM_CH),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PWM_MASK (PWM_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q),
    .wrap     (wrap),
    .step     (step),
    .ld       (ld),
    .count_v  (count_v),
    .reload_v (reload_v),
    .irq      (irq),
    .pwm_out  (pwm_out)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1m = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [7:0]  pwm_out;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done = 1'b0;
    logic [31:0] sh_ctl = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bank i_tmr_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_1m (tick_1m),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq),
        .pwm_out (pwm_out)
    );

    // register base of timer n (1-based), per R2
    function automatic logic [5:0] base(input int n);
        return (n <= 3) ? 6'(4 * (n - 1)) : 6'(4 * (n - 1) + 4);
    endfunction

    // control bits that exist, per R3 and R12
    function automatic logic [31:0] model_mask();
        logic [31:0] m;
        for (int n = 1; n <= 8; n++) m[4*(n-1) +: 4] = (n <= 4) ? 4'hF : 4'h7;
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [31:0] v);
        sh_ctl = v & model_mask();
        wr(6'd12, v);
    endtask

    task automatic ctl_clear(input logic [31:0] v);
        sh_ctl = sh_ctl & ~v;
        wr(6'd13, v);
    endtask

    task automatic tick_pulse();
        tick_1m = 1'b1;
        @(negedge clk);
        tick_1m = 1'b0;
    endtask

    // monitor: pops the scoreboard when read data is due
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL scoreboard empty actual=%h expected=none", rdata);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 pwm", {24'd0, pwm_out}, 32'd0);
        rd(base(1), 32'd0, "R1 count t1");
        rd(base(8) + 6'd1, 32'd0, "R1 reload t8");
        rd(6'd12, 32'd0, "R1 ctrl");
        rd(6'd14, 32'd0, "R1 flags");

        // R2 map around the control block
        wr(base(3) + 6'd1, 32'hA5A5_0003);
        wr(base(4) + 6'd1, 32'h1234_0004);
        wr(base(8) + 6'd2, 32'hCAFE_0008);
        wr(base(8) + 6'd3, 32'hBEEF_0008);
        rd(6'd9,  32'hA5A5_0003, "R2 reload t3");
        rd(6'd17, 32'h1234_0004, "R2 reload t4");
        rd(6'd34, 32'hCAFE_0008, "R2 match1 t8");
        rd(6'd35, 32'hBEEF_0008, "R2 match2 t8");

        // R13 reserved
        rd(6'd15, 32'd0, "R13 word15");
        rd(6'd40, 32'd0, "R13 word40");

        // R4 direct load and hold while disabled
        wr(base(2), 32'd100);
        idle(5);
        rd(base(2), 32'd100, "R4 load hold");

        // R3 / R5 slow tick source on timer 2
        ctl_write(32'h0000_0030);
        idle(1);
        tick_pulse(); idle(1);
        tick_pulse(); idle(1);
        tick_pulse(); idle(1);
        rd(base(2), 32'd97, "R5 three ticks");
        idle(4);
        rd(base(2), 32'd97, "R5 no tick hold");

        // R6 bus clock source on timer 5
        wr(base(5), 32'd50);
        ctl_write(sh_ctl | 32'h0001_0000);
        idle(5);
        ctl_clear(32'h0001_0000);
        rd(base(5), 32'd45, "R6 five cycles");
        rd(6'd12, sh_ctl, "R10 zeros keep bits");
        rd(6'd13, 32'd0, "R10 alias reads zero");
        ctl_clear(32'h0000_0030);
        rd(6'd12, 32'd0, "R10 ctrl cleared");

        // R7 / R8 / R9 wrap on timer 1
        wr(base(1) + 6'd1, 32'd4);
        wr(base(1), 32'd0);
        ctl_write(32'h0000_0007);
        idle(1);
        check("R9 irq before wrap", {31'd0, irq}, 32'd0);
        tick_pulse();
        check("R9 irq after wrap", {31'd0, irq}, 32'd1);
        rd(base(1), 32'd4, "R7 reload");
        rd(6'd14, 32'd1, "R7 flag set");
        wr(6'd14, 32'd0);
        rd(6'd14, 32'd1, "R8 zero keeps flag");
        ctl_clear(32'h0000_0004);
        check("R9 irq masked", {31'd0, irq}, 32'd0);
        wr(6'd14, 32'd1);
        rd(6'd14, 32'd0, "R8 flag cleared");
        ctl_clear(32'h0000_0001);

        // R11 pulse output on timer 4
        wr(base(4) + 6'd2, 32'd5);
        wr(base(4) + 6'd3, 32'd2);
        wr(base(4), 32'd7);
        ctl_write(32'h0000_B000);
        idle(1);
        check("R11 low at 7", {31'd0, pwm_out[3]}, 32'd0);
        tick_pulse(); idle(1);
        check("R11 low at 6", {31'd0, pwm_out[3]}, 32'd0);
        tick_pulse(); idle(1);
        check("R11 high at match1", {31'd0, pwm_out[3]}, 32'd1);
        tick_pulse(); idle(1);
        check("R11 high at 4", {31'd0, pwm_out[3]}, 32'd1);
        tick_pulse(); idle(1);
        check("R11 high at 3", {31'd0, pwm_out[3]}, 32'd1);
        tick_pulse(); idle(1);
        check("R11 low at match2", {31'd0, pwm_out[3]}, 32'd0);
        wr(base(4), 32'd5);
        idle(1);
        check("R11 high after load", {31'd0, pwm_out[3]}, 32'd1);
        ctl_clear(32'h0000_8000);
        idle(1);
        check("R11 off forces low", {31'd0, pwm_out[3]}, 32'd0);
        rd(base(4), 32'd5, "R4 loaded while running");

        // R12 timer 6 has no pulse support
        ctl_write(sh_ctl | 32'h00F0_0000);
        rd(6'd12, sh_ctl, "R12 bit3 reads zero");
        wr(base(6) + 6'd2, 32'd9);
        wr(base(6), 32'd9);
        idle(2);
        check("R12 output stays low", {31'd0, pwm_out[5]}, 32'd0);

        ctl_clear(32'hFFFF_FFFF);
        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule